// File: doc/BRIEF.md
# Register-Selected FPGA Pin Router

This block sits in a board management controller and decides which internal signal reaches each of four pins facing the main FPGA: three general pins (A, B, C) and one clock pin. A 16-bit routing word holds four 4-bit select fields, one per pin. Each field has its own sparse code set. Unlisted codes fall back to a pin-specific default source. Pins A, B and C also have a code that releases the pin, and each of these pins is presented as a data/enable pair. Writes to the routing word and to two small side registers come through a simple write port and take effect on the next clock edge. All routing itself is combinational.

Two open-drain-style auxiliary lines are derived from the same fields. The first is a shared pull-down line. The second is a MAC read line that is forced low. A 4-bit field in a second register selects the source of a board status pin. A 2-bit field in a third register picks which interrupt pin C carries in its interrupt mode.

Top module: `pin_router`

## Requirements
- R1: After reset the routing word, the status field and the interrupt select are all zero. Every pin therefore shows its default source: A shows phy_led[0], B shows phy_led[1], C shows phy_led[2], the clock pin shows phy_clk125 and the status pin shows phy_led[0]. A, B and C are enabled.
- R2: A write with wr_en=1 is seen on the outputs from the next clock edge. Address 0 loads all 16 bits of wr_data into the routing word. Address 1 loads wr_data[11:8] into the status field. Address 2 loads wr_data[1:0] into the interrupt select. A write to address 3, or any cycle with wr_en=0, changes nothing.
- R3: Pin A uses routing bits [3:0]. Code 0001 selects gpio7. Code 0010 drives 0, enabled only while the pull-down line is active. Code 0011 drives 0. Code 1000 selects uio_out. Every other code selects phy_led[0].
- R4: Pin B uses bits [7:4]. Code 0001 selects gpio14, 0011 selects rtc_irq and 1000 selects uio_out. Every other code selects phy_led[1].
- R5: Pin C uses bits [11:8]. Code 0001 selects gpio15, 0011 selects osc_clk, 1000 selects uio_out and 0111 selects the interrupt chosen by R11. Every other code selects phy_led[2].
- R6: The clock pin uses bits [15:12]. Code 0001 selects rtc_irq and 0010 selects osc_clk. Every other code selects phy_clk125. The clock pin has no release code.
- R7: Code 0110 in the field of pin A, B or C drives that pin's enable low. Every other code except pin A's 0010 keeps the enable high.
- R8: sha_pull is 1 exactly when bits [3:0] equal 0010 and pin B is enabled and driving 0.
- R9: mac_o is 0 when bits [3:0] equal 0011 and follows mac_rd otherwise.
- R10: The status pin selects phy_led[0], phy_led[1], phy_led[2], gpio7 or rtc_irq for field codes 0001 to 0101 in that order. Code 0110 gives 0, 0111 gives 1 and 1000 gives pin C's data. Every other code selects phy_led[0].
- R11: The interrupt select values are 00 for irq1, 01 for irq2, 10 for rtc_irq and 11 for phy_led[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for a write |
| wr_data | input | 16 | Write data |
| gpio7 | input | 1 | Processor GPIO 7 |
| gpio14 | input | 1 | Processor GPIO 14 |
| gpio15 | input | 1 | Processor GPIO 15 |
| rtc_irq | input | 1 | Real-time clock interrupt |
| irq1 | input | 1 | Interrupt source 1 |
| irq2 | input | 1 | Interrupt source 2 |
| osc_clk | input | 1 | On-chip oscillator (about 24.18 MHz) |
| phy_clk125 | input | 1 | 125 MHz Ethernet PHY clock |
| phy_led | input | 3 | Ethernet PHY LED lines 0..2 |
| uio_out | input | 1 | Unidirectional user-I/O output |
| mac_rd | input | 1 | Internal MAC read signal |
| pin_a_o | output | 1 | Pin A data |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_o | output | 1 | Pin B data |
| pin_b_oe | output | 1 | Pin B output enable |
| pin_c_o | output | 1 | Pin C data |
| pin_c_oe | output | 1 | Pin C output enable |
| clk_pin_o | output | 1 | Clock pin |
| sha_pull | output | 1 | Pull-down line active (drive low) |
| mac_o | output | 1 | MAC read line |
| stat_led_o | output | 1 | Status pin |

## Verification
On every cycle the assertions check these properties. Release codes must drop the enables. The pull-down line must only be active when pin A selects it and pin B is enabled and driving low. The MAC line must stay low in its forced code. The clock pin must follow the PHY clock in its default code. The status pin must follow pin C, or hold at 0, in the matching codes. Writes and non-writes must load or leave the routing word. The full code tables need the bench's field sweeps under random source values. So do the fallback for every unlisted code, the interrupt selection and the ignored address 3.

// File: rtl/pin_router_pkg.sv
package pin_router_pkg;
  localparam int FIELD_W   = 4;
  localparam int IRQ_SEL_W = 2;
  localparam int ADDR_W    = 2;

  // register addresses
  localparam int REG_ROUTE = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_IRQ   = 2;

  // pin field codes
  localparam logic [FIELD_W-1:0] SEL_ALT1 = 4'b0001;
  localparam logic [FIELD_W-1:0] SEL_ALT2 = 4'b0010;
  localparam logic [FIELD_W-1:0] SEL_ALT3 = 4'b0011;
  localparam logic [FIELD_W-1:0] SEL_HIZ  = 4'b0110;
  localparam logic [FIELD_W-1:0] SEL_IRQ  = 4'b0111;
  localparam logic [FIELD_W-1:0] SEL_UIO  = 4'b1000;

  // status field codes
  localparam logic [FIELD_W-1:0] ST_LED0  = 4'b0001;
  localparam logic [FIELD_W-1:0] ST_LED1  = 4'b0010;
  localparam logic [FIELD_W-1:0] ST_LED2  = 4'b0011;
  localparam logic [FIELD_W-1:0] ST_GPIO7 = 4'b0100;
  localparam logic [FIELD_W-1:0] ST_RTC   = 4'b0101;
  localparam logic [FIELD_W-1:0] ST_OFF   = 4'b0110;
  localparam logic [FIELD_W-1:0] ST_ON    = 4'b0111;
  localparam logic [FIELD_W-1:0] ST_PINC  = 4'b1000;

  typedef struct packed {
    logic d;
    logic oe;
  } pin_drv_t;
endpackage

// File: rtl/pin_router_regs.sv
module pin_router_regs
  import pin_router_pkg::*;
#(
  parameter int WORD_W = 4 * FIELD_W,
  parameter int STAT_LSB = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic                 rst_sync_n,
  output logic [WORD_W-1:0]    route_q,
  output logic [FIELD_W-1:0]   stat_q,
  output logic [IRQ_SEL_W-1:0] irq_q
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]    sync_q;
  logic [WORD_W-1:0]    route_d;
  logic [FIELD_W-1:0]   stat_d;
  logic [IRQ_SEL_W-1:0] irq_d;
  logic                 route_en, stat_en, irq_en;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_N-1];

  always_comb begin
    route_en = wr_en && (wr_addr == ADDR_W'(REG_ROUTE));
    stat_en  = wr_en && (wr_addr == ADDR_W'(REG_STAT));
    irq_en   = wr_en && (wr_addr == ADDR_W'(REG_IRQ));
    route_d  = wr_data;
    stat_d   = wr_data[STAT_LSB +: FIELD_W];
    irq_d    = wr_data[IRQ_SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      route_q <= '0;
      stat_q  <= '0;
      irq_q   <= '0;
    end else begin
      if (route_en) route_q <= route_d;
      if (stat_en)  stat_q  <= stat_d;
      if (irq_en)   irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/pin_router_fpga_pins.sv
module pin_router_fpga_pins
  import pin_router_pkg::*;
#(
  parameter int WORD_W = 4 * FIELD_W,
  parameter int LED_N  = 3
) (
  input  logic [WORD_W-1:0]    route,
  input  logic [IRQ_SEL_W-1:0] irq_sel,
  input  logic                 gpio7,
  input  logic                 gpio14,
  input  logic                 gpio15,
  input  logic                 rtc_irq,
  input  logic                 irq1,
  input  logic                 irq2,
  input  logic                 osc_clk,
  input  logic                 phy_clk125,
  input  logic [LED_N-1:0]     phy_led,
  input  logic                 uio_out,
  input  logic                 mac_rd,
  output pin_drv_t             pin_a,
  output pin_drv_t             pin_b,
  output pin_drv_t             pin_c,
  output logic                 clk_pin,
  output logic                 sha_pull,
  output logic                 mac_line
);
  logic [FIELD_W-1:0] fa, fb, fc, fk;
  logic               irq_mux;

  assign fa = route[0*FIELD_W +: FIELD_W];
  assign fb = route[1*FIELD_W +: FIELD_W];
  assign fc = route[2*FIELD_W +: FIELD_W];
  assign fk = route[3*FIELD_W +: FIELD_W];

  always_comb begin
    unique case (irq_sel)
      IRQ_SEL_W'(0): irq_mux = irq1;
      IRQ_SEL_W'(1): irq_mux = irq2;
      IRQ_SEL_W'(2): irq_mux = rtc_irq;
      default:       irq_mux = phy_led[2];
    endcase
  end

  // pin B first: the pull-down line depends on it
  always_comb begin
    pin_b.oe = (fb != SEL_HIZ);
    case (fb)
      SEL_ALT1: pin_b.d = gpio14;
      SEL_ALT3: pin_b.d = rtc_irq;
      SEL_UIO:  pin_b.d = uio_out;
      default:  pin_b.d = phy_led[1];
    endcase
  end

  always_comb begin
    sha_pull = (fa == SEL_ALT2) && pin_b.oe && !pin_b.d;
    mac_line = (fa == SEL_ALT3) ? 1'b0 : mac_rd;
  end

  always_comb begin
    pin_a.oe = 1'b1;
    case (fa)
      SEL_ALT1: pin_a.d = gpio7;
      SEL_ALT2: begin
        pin_a.d  = 1'b0;
        pin_a.oe = sha_pull;
      end
      SEL_ALT3: pin_a.d = mac_line;
      SEL_UIO:  pin_a.d = uio_out;
      SEL_HIZ: begin
        pin_a.d  = phy_led[0];
        pin_a.oe = 1'b0;
      end
      default:  pin_a.d = phy_led[0];
    endcase
  end

  always_comb begin
    pin_c.oe = (fc != SEL_HIZ);
    case (fc)
      SEL_ALT1: pin_c.d = gpio15;
      SEL_ALT3: pin_c.d = osc_clk;
      SEL_UIO:  pin_c.d = uio_out;
      SEL_IRQ:  pin_c.d = irq_mux;
      default:  pin_c.d = phy_led[2];
    endcase
  end

  always_comb begin
    case (fk)
      SEL_ALT1: clk_pin = rtc_irq;
      SEL_ALT2: clk_pin = osc_clk;
      default:  clk_pin = phy_clk125;
    endcase
  end
endmodule

// File: rtl/pin_router_status.sv
module pin_router_status
  import pin_router_pkg::*;
#(
  parameter int LED_N = 3
) (
  input  logic [FIELD_W-1:0] sel,
  input  logic [LED_N-1:0]   phy_led,
  input  logic               gpio7,
  input  logic               rtc_irq,
  input  logic               pin_c_d,
  output logic               stat_led
);
  always_comb begin
    case (sel)
      ST_LED0:  stat_led = phy_led[0];
      ST_LED1:  stat_led = phy_led[1];
      ST_LED2:  stat_led = phy_led[2];
      ST_GPIO7: stat_led = gpio7;
      ST_RTC:   stat_led = rtc_irq;
      ST_OFF:   stat_led = 1'b0;
      ST_ON:    stat_led = 1'b1;
      ST_PINC:  stat_led = pin_c_d;
      default:  stat_led = phy_led[0];
    endcase
  end
endmodule

// File: rtl/pin_router.sv
module pin_router
  import pin_router_pkg::*;
#(
  parameter int LED_N = 3,
  parameter int STAT_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             gpio7,
  input  logic             gpio14,
  input  logic             gpio15,
  input  logic             rtc_irq,
  input  logic             irq1,
  input  logic             irq2,
  input  logic             osc_clk,
  input  logic             phy_clk125,
  input  logic [LED_N-1:0] phy_led,
  input  logic             uio_out,
  input  logic             mac_rd,
  output logic             pin_a_o,
  output logic             pin_a_oe,
  output logic             pin_b_o,
  output logic             pin_b_oe,
  output logic             pin_c_o,
  output logic             pin_c_oe,
  output logic             clk_pin_o,
  output logic             sha_pull,
  output logic             mac_o,
  output logic             stat_led_o
);
  localparam int WORD_W = 4 * FIELD_W;

  logic                 rst_sync_n;
  logic [WORD_W-1:0]    route_q;
  logic [FIELD_W-1:0]   stat_q;
  logic [IRQ_SEL_W-1:0] irq_q;
  pin_drv_t             drv_a, drv_b, drv_c;

  pin_router_regs #(.WORD_W(WORD_W), .STAT_LSB(STAT_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_sync_n(rst_sync_n), .route_q(route_q),
    .stat_q(stat_q), .irq_q(irq_q)
  );

  pin_router_fpga_pins #(.WORD_W(WORD_W), .LED_N(LED_N)) u_pins (
    .route(route_q), .irq_sel(irq_q), .gpio7(gpio7), .gpio14(gpio14),
    .gpio15(gpio15), .rtc_irq(rtc_irq), .irq1(irq1), .irq2(irq2),
    .osc_clk(osc_clk), .phy_clk125(phy_clk125), .phy_led(phy_led),
    .uio_out(uio_out), .mac_rd(mac_rd), .pin_a(drv_a), .pin_b(drv_b),
    .pin_c(drv_c), .clk_pin(clk_pin_o), .sha_pull(sha_pull), .mac_line(mac_o)
  );

  pin_router_status #(.LED_N(LED_N)) u_stat (
    .sel(stat_q), .phy_led(phy_led), .gpio7(gpio7), .rtc_irq(rtc_irq),
    .pin_c_d(drv_c.d), .stat_led(stat_led_o)
  );

  assign pin_a_o  = drv_a.d;
  assign pin_a_oe = drv_a.oe;
  assign pin_b_o  = drv_b.d;
  assign pin_b_oe = drv_b.oe;
  assign pin_c_o  = drv_c.d;
  assign pin_c_oe = drv_c.oe;
endmodule

// File: rtl/pin_router_chk.sv
module pin_router_chk
  import pin_router_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [15:0]        wr_data,
  input logic [15:0]        route,
  input logic [FIELD_W-1:0] stat_sel,
  input logic               pin_a_oe,
  input logic               pin_b_o,
  input logic               pin_b_oe,
  input logic               pin_c_o,
  input logic               pin_c_oe,
  input logic               clk_pin_o,
  input logic               phy_clk125,
  input logic               sha_pull,
  input logic               mac_o,
  input logic               stat_led_o
);
  // R1
  rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (route == '0 && stat_sel == '0));
  // R2
  route_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (route == $past(wr_data)));
  // R2
  route_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd0) |=> $stable(route));
  // R7
  a_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route[3:0] == SEL_HIZ) |-> !pin_a_oe);
  // R7
  b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route[7:4] == SEL_HIZ) |-> !pin_b_oe);
  // R7
  c_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route[11:8] == SEL_HIZ) |-> !pin_c_oe);
  // R8
  sha_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sha_pull |-> (route[3:0] == SEL_ALT2 && pin_b_oe && !pin_b_o));
  // R9
  mac_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route[3:0] == SEL_ALT3) |-> !mac_o);
  // R6
  clk_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route[15:12] == 4'b0000) |-> (clk_pin_o == phy_clk125));
  // R10
  stat_pinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel == ST_PINC) |-> (stat_led_o == pin_c_o));
  // R10
  stat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel == ST_OFF) |-> !stat_led_o);
endmodule

bind pin_router pin_router_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .route(route_q), .stat_sel(stat_q),
  .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe),
  .pin_c_o(pin_c_o), .pin_c_oe(pin_c_oe), .clk_pin_o(clk_pin_o),
  .phy_clk125(phy_clk125), .sha_pull(sha_pull), .mac_o(mac_o),
  .stat_led_o(stat_led_o)
);

// File: tb/pin_router_test.sv
module pin_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic gpio7 = 0, gpio14 = 0, gpio15 = 0, rtc_irq = 0, irq1 = 0, irq2 = 0;
  logic osc_clk = 0, phy_clk125 = 0, uio_out = 0, mac_rd = 0;
  logic [2:0] phy_led = '0;
  logic pin_a_o, pin_a_oe, pin_b_o, pin_b_oe, pin_c_o, pin_c_oe;
  logic clk_pin_o, sha_pull, mac_o, stat_led_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [15:0] m_route;
  logic [3:0]  m_stat;
  logic [1:0]  m_irq;

  always #2 clk = ~clk;

  pin_router uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gpio7(gpio7), .gpio14(gpio14), .gpio15(gpio15), .rtc_irq(rtc_irq),
    .irq1(irq1), .irq2(irq2), .osc_clk(osc_clk), .phy_clk125(phy_clk125),
    .phy_led(phy_led), .uio_out(uio_out), .mac_rd(mac_rd),
    .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe),
    .pin_c_o(pin_c_o), .pin_c_oe(pin_c_oe), .clk_pin_o(clk_pin_o),
    .sha_pull(sha_pull), .mac_o(mac_o), .stat_led_o(stat_led_o)
  );

  // R2: reference register update, only address 0..2 with wr_en
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_route <= 16'h0000; m_stat <= 4'h0; m_irq <= 2'b00;
    end else if (wr_en) begin
      if (wr_addr == 2'd0) m_route <= wr_data;
      else if (wr_addr == 2'd1) m_stat <= wr_data[11:8];
      else if (wr_addr == 2'd2) m_irq <= wr_data[1:0];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    int fa = m_route[3:0], fb = m_route[7:4], fc = m_route[11:8], fk = m_route[15:12];
    logic ea, eao, eb, ebo, ec, eco, ek, esha, emac, est, eirq;
    // R11 interrupt choice
    if (m_irq == 2'd0) eirq = irq1;
    else if (m_irq == 2'd1) eirq = irq2;
    else if (m_irq == 2'd2) eirq = rtc_irq;
    else eirq = phy_led[2];
    // R4
    ebo = (fb != 6);
    eb = (fb == 1) ? gpio14 : (fb == 3) ? rtc_irq : (fb == 8) ? uio_out : phy_led[1];
    // R8, R9
    esha = (fa == 2) && ebo && (eb == 1'b0);
    emac = (fa == 3) ? 1'b0 : mac_rd;
    // R3, R7
    eao = (fa == 6) ? 1'b0 : (fa == 2) ? esha : 1'b1;
    if (fa == 1) ea = gpio7;
    else if (fa == 2 || fa == 3) ea = 1'b0;
    else if (fa == 8) ea = uio_out;
    else ea = phy_led[0];
    // R5
    eco = (fc != 6);
    if (fc == 1) ec = gpio15;
    else if (fc == 3) ec = osc_clk;
    else if (fc == 8) ec = uio_out;
    else if (fc == 7) ec = eirq;
    else ec = phy_led[2];
    // R6
    ek = (fk == 1) ? rtc_irq : (fk == 2) ? osc_clk : phy_clk125;
    // R10
    case (m_stat)
      4'd1: est = phy_led[0];
      4'd2: est = phy_led[1];
      4'd3: est = phy_led[2];
      4'd4: est = gpio7;
      4'd5: est = rtc_irq;
      4'd6: est = 1'b0;
      4'd7: est = 1'b1;
      4'd8: est = ec;
      default: est = phy_led[0];
    endcase
    chk("R3", {tag, " pin_a_o"}, pin_a_o, ea);
    chk("R7", {tag, " pin_a_oe"}, pin_a_oe, eao);
    chk("R4", {tag, " pin_b_o"}, pin_b_o, eb);
    chk("R7", {tag, " pin_b_oe"}, pin_b_oe, ebo);
    chk((fc == 7) ? "R11" : "R5", {tag, " pin_c_o"}, pin_c_o, ec);
    chk("R7", {tag, " pin_c_oe"}, pin_c_oe, eco);
    chk("R6", {tag, " clk_pin_o"}, clk_pin_o, ek);
    chk("R8", {tag, " sha_pull"}, sha_pull, esha);
    chk("R9", {tag, " mac_o"}, mac_o, emac);
    chk("R10", {tag, " stat_led_o"}, stat_led_o, est);
  endtask

  task automatic shake_sources();
    {gpio7, gpio14, gpio15, rtc_irq, irq1, irq2, osc_clk, phy_clk125, uio_out, mac_rd} = 10'($urandom);
    phy_led = 3'($urandom);
  endtask

  // one cycle: drive at negedge, compare before the next rising edge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    shake_sources();
    #1 compare_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 2'd0, 16'h0, "R1 reset defaults");
    // R3..R7: every code in every routing field
    for (int f = 0; f < 4; f++) begin
      for (int c = 0; c < 16; c++) begin
        logic [15:0] w = 16'($urandom);
        w[f*4 +: 4] = 4'(c);
        cyc(1'b1, 2'd0, w, "R2 route write");
        repeat (4) cyc(1'b0, 2'd0, 16'($urandom), "R2 no write, field sweep");
      end
    end
    // R10 status codes, with pin C in various modes
    for (int c = 0; c < 16; c++) begin
      cyc(1'b1, 2'd1, {4'($urandom), 4'(c), 8'($urandom)}, "R10 status write");
      cyc(1'b1, 2'd0, 16'($urandom), "R10 route change");
      repeat (4) cyc(1'b0, 2'd1, 16'($urandom), "R10 status hold");
    end
    // R11 interrupt select with pin C in interrupt mode
    cyc(1'b1, 2'd0, 16'h0700, "R11 pin C irq mode");
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 2'd2, {14'($urandom), 2'(s)}, "R11 select write");
      repeat (6) cyc(1'b0, 2'd0, 16'h0, "R11 select hold");
    end
    // R8 pull-down line against every pin B code
    for (int b = 0; b < 16; b++) begin
      cyc(1'b1, 2'd0, {8'($urandom), 4'(b), 4'b0010}, "R8 sha sweep");
      repeat (6) cyc(1'b0, 2'd0, 16'h0, "R8 sha hold");
    end
    // R2 address 3 is ignored
    cyc(1'b1, 2'd0, 16'h1234, "R2 known word");
    repeat (8) cyc(1'b1, 2'd3, 16'($urandom), "R2 address 3 ignored");
    // mixed random traffic
    repeat (3000) cyc(1'($urandom), 2'($urandom), 16'($urandom), "R2 random traffic");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule